// File: doc/BRIEF.md
# Break and Output-Enable Controller

This block is the fault-protection core of a complementary-output PWM timer. Two break inputs, each with an enable and a polarity bit, can switch off a main output-enable flag at once. Software sets that flag again, or it is set again automatically at the next update event once no break is present. The flag and two off-state selection bits (one for run mode, one for idle mode) decide whether each leg of one complementary pair carries its PWM signal, is held at its inactive level, is held at its programmed idle level, or is released to high impedance.

Each break input can also work as a bidirectional open-drain pin. A break event pulls that pin low to tell external devices about the fault. Software releases the pin through a disarm bit, and hardware clears that bit again when the fault has gone. A sticky flag records that a break event has occurred. Input filtering and dead-time generation lie outside this block. The dead-time result comes in as a single "dead-time elapsed" input.

Top module: `brk_guard`

## Requirements
- R1: After a synchronous reset, `moe`, `brk_flag`, every bit of `brk_pin_low` and `dsrm`, and both output enables are 0.
- R2: Break input i counts as active when its live enable bit is 1 and `brk_in[i]` equals its live polarity bit (polarity 0 = active low, 1 = active high). While any break is active, `moe` is 0 in the same cycle, with no clock edge needed. The internal flag is cleared, so `moe` stays 0 after the break goes away.
- R3: A `moe_set` pulse sets `moe` at the next rising edge and a `moe_clr` pulse clears it there. When a break is active, `moe_set` has no effect.
- R4: With `cfg_aoe`=1, an `upd_evt` pulse sets `moe` at the next edge if no break is active. With `cfg_aoe`=0, `upd_evt` has no effect.
- R5: A `cfg_wr` pulse captures every `cfg_*` field at the rising edge. Enable, polarity and bidirectional bits act one edge later. The off-state, automatic-enable and idle-level bits act right after the capturing edge.
- R6: When `moe`=1 and a leg's channel enable is 1, that leg outputs its PWM input with its output enable at 1.
- R7: When `moe`=1 and a leg's channel enable is 0, the leg outputs 0. Its output enable equals `cfg_ossr`.
- R8: When `moe`=0 and `cfg_ossi`=0, both output enables are 0 and both outputs are 0. When `moe`=0 and `cfg_ossi`=1, both output enables are 1. Both outputs are 0 while `dt_idle_ok`=0 and equal their idle levels (`cfg_idle_p`, `cfg_idle_n`) while it is 1.
- R9: Break inputs with index 1 and above can act only while `cfg_ossi` and `cfg_ossr` are both 1. Otherwise they are ignored.
- R10: When a channel's bidirectional bit is 1 and its break is active while it is not disarmed, `brk_pin_low[i]` rises at the next edge. It stays high after the break goes away. It is never high when the bidirectional bit is 0.
- R11: A `dsrm_wr[i]` pulse sets `dsrm[i]` two edges later. The edge after that, `brk_pin_low[i]` is released. Hardware clears `dsrm[i]` at the first edge where channel i's break is inactive.
- R12: `brk_flag` is set at the edge after any active break and stays set until a `flag_clr` pulse arrives with no break active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_brk_en | input | NBRK | Break enable per input |
| cfg_brk_pol | input | NBRK | Break polarity per input (1 = active high) |
| cfg_brk_bid | input | NBRK | Bidirectional pin mode per input |
| cfg_aoe | input | 1 | Automatic re-enable at update event |
| cfg_ossi | input | 1 | Idle-mode off-state selection |
| cfg_ossr | input | 1 | Run-mode off-state selection |
| cfg_idle_p | input | 1 | Idle level of the main leg |
| cfg_idle_n | input | 1 | Idle level of the complementary leg |
| moe_set | input | 1 | Software set of the main output enable |
| moe_clr | input | 1 | Software clear of the main output enable |
| flag_clr | input | 1 | Software clear of the break flag |
| dsrm_wr | input | NBRK | Software disarm request per input |
| upd_evt | input | 1 | Update-event pulse |
| brk_in | input | NBRK | Filtered break inputs |
| pwm_p | input | 1 | Raw PWM main leg |
| pwm_n | input | 1 | Raw PWM complementary leg |
| ch_en_p | input | 1 | Channel enable, main leg |
| ch_en_n | input | 1 | Channel enable, complementary leg |
| dt_idle_ok | input | 1 | Dead-time elapsed, idle levels may be applied |
| out_p | output | 1 | Gated main leg |
| out_n | output | 1 | Gated complementary leg |
| oe_p | output | 1 | Output enable, main leg |
| oe_n | output | 1 | Output enable, complementary leg |
| brk_pin_low | output | NBRK | Open-drain pull-low request per break pin |
| moe | output | 1 | Effective main output enable |
| brk_flag | output | 1 | Sticky break status |
| dsrm | output | NBRK | Disarm state per input |

## Verification
The assertions check these rules on every cycle:
- an active break clears the flag and sets the sticky status;
- the automatic re-enable fires at an update event, and the flag never sets itself without a cause;
- a disarmed pin is released and hardware clears the disarm bit;
- upper break inputs are gated by the off-state bits;
- the idle-mode release holds whenever the output enable is off.

Only the bench scenarios can show the cycle counts:
- the same-cycle drop of `moe` on a break;
- the one-edge lag of the break configuration against the immediate off-state bits;
- the two-edge disarm path;
- the full truth table of the output gating across run and idle modes.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned BRK_CNT = 2;

  typedef struct packed {
    logic en;
    logic pol;
    logic bid;
  } brk_cfg_t;
endpackage

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_wr,
  input  brk_cfg_t cfg_in,
  input  logic     gate_ok,
  input  logic     brk_in,
  input  logic     dsrm_wr,
  output logic     act,
  output logic     pin_low,
  output logic     dsrm
);
  brk_cfg_t shadow_q, live_q;
  logic     pend_q, dsrm_q, pin_q;

  // Captured at the write edge; live one edge later.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      live_q   <= '0;
    end else begin
      if (cfg_wr) shadow_q <= cfg_in;
      live_q <= shadow_q;
    end
  end

  assign act = live_q.en & gate_ok & (brk_in == live_q.pol);

  // Disarm handshake: request lags one edge; hardware clears when source is quiet.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      dsrm_q <= 1'b0;
    end else begin
      pend_q <= dsrm_wr;
      if (pend_q)    dsrm_q <= 1'b1;
      else if (!act) dsrm_q <= 1'b0;
    end
  end

  // Open-drain pull-low: held after the fault until disarmed.
  always_ff @(posedge clk) begin
    if (rst)                       pin_q <= 1'b0;
    else if (dsrm_q || !live_q.bid) pin_q <= 1'b0;
    else if (act)                  pin_q <= 1'b1;
  end

  assign pin_low = pin_q;
  assign dsrm    = dsrm_q;

  // R10: an undisarmed active break in bidirectional mode drives the pin.
  a_r10_pin_drive: assert property (@(posedge clk) disable iff (rst)
    (live_q.bid && act && !dsrm_q) |=> pin_q);
  // R11: a disarmed channel releases its pin.
  a_r11_release: assert property (@(posedge clk) disable iff (rst)
    dsrm_q |=> !pin_q);
  // R11: hardware clears disarm once the source is inactive.
  a_r11_hw_clear: assert property (@(posedge clk) disable iff (rst)
    (dsrm_q && !act && !pend_q) |=> !dsrm_q);
endmodule

// File: rtl/moe_ctrl.sv
module moe_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic brk_any,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic upd,
  input  logic aoe,
  input  logic flag_clr,
  output logic moe_q,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)                        moe_q <= 1'b0;
    else if (brk_any)               moe_q <= 1'b0;
    else if (sw_clr)                moe_q <= 1'b0;
    else if (sw_set || (aoe && upd)) moe_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (brk_any)  flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  // R2/R3: a break leaves the stored enable cleared.
  a_r3_break_wins: assert property (@(posedge clk) disable iff (rst)
    brk_any |=> !moe_q);
  // R4: automatic re-enable at an update event.
  a_r4_auto_set: assert property (@(posedge clk) disable iff (rst)
    (aoe && upd && !brk_any && !sw_clr) |=> moe_q);
  // R4: no set without a software or update cause.
  a_r4_no_spont: assert property (@(posedge clk) disable iff (rst)
    (!moe_q && !sw_set && !(aoe && upd)) |=> !moe_q);
  // R12: sticky status.
  a_r12_flag_set: assert property (@(posedge clk) disable iff (rst)
    brk_any |=> flag_q);
  a_r12_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int unsigned LEGS = 2
) (
  input  logic            moe_on,
  input  logic            ossi,
  input  logic            ossr,
  input  logic            dt_ok,
  input  logic [LEGS-1:0] pwm,
  input  logic [LEGS-1:0] ch_en,
  input  logic [LEGS-1:0] idle,
  output logic [LEGS-1:0] pin,
  output logic [LEGS-1:0] oe
);
  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    always_comb begin
      if (moe_on) begin
        if (ch_en[i]) begin
          pin[i] = pwm[i];
          oe[i]  = 1'b1;
        end else begin
          pin[i] = 1'b0;
          oe[i]  = ossr;
        end
      end else begin
        oe[i]  = ossi;
        pin[i] = ossi & dt_ok & idle[i];
      end
    end
  end
endmodule

// File: rtl/brk_guard.sv
module brk_guard
  import brk_pkg::*;
#(
  parameter int unsigned NBRK = BRK_CNT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [NBRK-1:0] cfg_brk_en,
  input  logic [NBRK-1:0] cfg_brk_pol,
  input  logic [NBRK-1:0] cfg_brk_bid,
  input  logic            cfg_aoe,
  input  logic            cfg_ossi,
  input  logic            cfg_ossr,
  input  logic            cfg_idle_p,
  input  logic            cfg_idle_n,
  input  logic            moe_set,
  input  logic            moe_clr,
  input  logic            flag_clr,
  input  logic [NBRK-1:0] dsrm_wr,
  input  logic            upd_evt,
  input  logic [NBRK-1:0] brk_in,
  input  logic            pwm_p,
  input  logic            pwm_n,
  input  logic            ch_en_p,
  input  logic            ch_en_n,
  input  logic            dt_idle_ok,
  output logic            out_p,
  output logic            out_n,
  output logic            oe_p,
  output logic            oe_n,
  output logic [NBRK-1:0] brk_pin_low,
  output logic            moe,
  output logic            brk_flag,
  output logic [NBRK-1:0] dsrm
);
  localparam int unsigned LEGS = 2;

  logic            aoe_q, ossi_q, ossr_q, idle_p_q, idle_n_q;
  logic [NBRK-1:0] act_v;
  logic            brk_any, moe_q;
  logic [LEGS-1:0] leg_pin, leg_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      aoe_q    <= 1'b0;
      ossi_q   <= 1'b0;
      ossr_q   <= 1'b0;
      idle_p_q <= 1'b0;
      idle_n_q <= 1'b0;
    end else if (cfg_wr) begin
      aoe_q    <= cfg_aoe;
      ossi_q   <= cfg_ossi;
      ossr_q   <= cfg_ossr;
      idle_p_q <= cfg_idle_p;
      idle_n_q <= cfg_idle_n;
    end
  end

  for (genvar i = 0; i < NBRK; i++) begin : g_brk
    brk_cfg_t cfg_i;
    logic     gate_i;
    assign cfg_i  = '{en: cfg_brk_en[i], pol: cfg_brk_pol[i], bid: cfg_brk_bid[i]};
    if (i == 0) begin : g_first
      assign gate_i = 1'b1;
    end else begin : g_upper
      assign gate_i = ossi_q & ossr_q;
    end
    brk_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .cfg_wr  (cfg_wr),
      .cfg_in  (cfg_i),
      .gate_ok (gate_i),
      .brk_in  (brk_in[i]),
      .dsrm_wr (dsrm_wr[i]),
      .act     (act_v[i]),
      .pin_low (brk_pin_low[i]),
      .dsrm    (dsrm[i])
    );
  end

  assign brk_any = |act_v;

  moe_ctrl u_moe (
    .clk      (clk),
    .rst      (rst),
    .brk_any  (brk_any),
    .sw_set   (moe_set),
    .sw_clr   (moe_clr),
    .upd      (upd_evt),
    .aoe      (aoe_q),
    .flag_clr (flag_clr),
    .moe_q    (moe_q),
    .flag_q   (brk_flag)
  );

  // Immediate clear path: no edge between break and output shutdown.
  assign moe = moe_q & ~brk_any;

  out_gate #(.LEGS(LEGS)) u_gate (
    .moe_on (moe),
    .ossi   (ossi_q),
    .ossr   (ossr_q),
    .dt_ok  (dt_idle_ok),
    .pwm    ({pwm_n, pwm_p}),
    .ch_en  ({ch_en_n, ch_en_p}),
    .idle   ({idle_n_q, idle_p_q}),
    .pin    (leg_pin),
    .oe     (leg_oe)
  );

  assign out_p = leg_pin[0];
  assign out_n = leg_pin[1];
  assign oe_p  = leg_oe[0];
  assign oe_n  = leg_oe[1];

  // R8: idle mode with release selected drives nothing.
  a_r8_idle_release: assert property (@(posedge clk) disable iff (rst)
    (brk_any && !ossi_q) |-> (!oe_p && !oe_n));
  // R6: run mode passes the PWM leg.
  a_r6_run_pass: assert property (@(posedge clk) disable iff (rst)
    (moe && ch_en_p) |-> (oe_p && (out_p == pwm_p)));
  // R9: upper break inputs are ignored unless both off-state bits are set.
  a_r9_upper_gated: assert property (@(posedge clk) disable iff (rst)
    !(ossi_q && ossr_q) |-> (act_v[NBRK-1:1] == '0));
endmodule

// File: tb/brk_guard_tb.sv
module brk_guard_tb;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_aoe = 0, cfg_ossi = 0, cfg_ossr = 0, cfg_idle_p = 0, cfg_idle_n = 0;
  logic [NB-1:0] cfg_brk_en = '0, cfg_brk_pol = '0, cfg_brk_bid = '0, dsrm_wr = '0, brk_in = '0;
  logic moe_set = 0, moe_clr = 0, flag_clr = 0, upd_evt = 0;
  logic pwm_p = 0, pwm_n = 0, ch_en_p = 0, ch_en_n = 0, dt_idle_ok = 0;
  logic out_p, out_n, oe_p, oe_n, moe, brk_flag;
  logic [NB-1:0] brk_pin_low, dsrm;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  brk_guard u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_brk_en(cfg_brk_en),
    .cfg_brk_pol(cfg_brk_pol), .cfg_brk_bid(cfg_brk_bid), .cfg_aoe(cfg_aoe),
    .cfg_ossi(cfg_ossi), .cfg_ossr(cfg_ossr), .cfg_idle_p(cfg_idle_p),
    .cfg_idle_n(cfg_idle_n), .moe_set(moe_set), .moe_clr(moe_clr),
    .flag_clr(flag_clr), .dsrm_wr(dsrm_wr), .upd_evt(upd_evt), .brk_in(brk_in),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .ch_en_p(ch_en_p), .ch_en_n(ch_en_n),
    .dt_idle_ok(dt_idle_ok), .out_p(out_p), .out_n(out_n), .oe_p(oe_p),
    .oe_n(oe_n), .brk_pin_low(brk_pin_low), .moe(moe), .brk_flag(brk_flag),
    .dsrm(dsrm)
  );

  // {moe, ossi, ossr, idle_p, idle_n, en_p, en_n, pwm_p, pwm_n, dt | out_p, out_n, oe_p, oe_n}
  localparam logic [13:0] VEC [8] = '{
    14'b10000111001011,
    14'b10000110100111,
    14'b10000011100101,
    14'b10100001100011,
    14'b00000111100000,
    14'b01011000000011,
    14'b01010000011011,
    14'b01001111010111
  };

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic cfg(input logic [NB-1:0] en, input logic [NB-1:0] pol,
                     input logic [NB-1:0] bid, input logic aoe,
                     input logic ossi, input logic ossr);
    @(negedge clk);
    cfg_brk_en = en; cfg_brk_pol = pol; cfg_brk_bid = bid;
    cfg_aoe = aoe; cfg_ossi = ossi; cfg_ossr = ossr;
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic pulse_set();
    moe_set = 1; @(negedge clk); moe_set = 0;
  endtask

  task automatic pulse_clr_flag();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 moe", moe, 0);
    chk("R1 flag", brk_flag, 0);
    chk("R1 pin", brk_pin_low[0], 0);
    chk("R1 dsrm", dsrm[0], 0);
    chk("R1 oe_p", oe_p, 0);
    chk("R1 oe_n", oe_n, 0);

    // Gating table: R6 / R7 / R8
    for (int k = 0; k < 8; k++) begin
      logic [13:0] v;
      string req;
      v = VEC[k];
      req = v[13] ? ((v[8] & v[7]) ? "R6" : "R7") : "R8";
      @(negedge clk);
      cfg_brk_en = '0; cfg_ossi = v[12]; cfg_ossr = v[11];
      cfg_idle_p = v[10]; cfg_idle_n = v[9]; cfg_wr = 1;
      moe_set = v[13]; moe_clr = ~v[13];
      ch_en_p = v[8]; ch_en_n = v[7]; pwm_p = v[6]; pwm_n = v[5]; dt_idle_ok = v[4];
      @(negedge clk);
      cfg_wr = 0; moe_set = 0; moe_clr = 0;
      #1;
      chk(req, out_p, v[3]);
      chk(req, out_n, v[2]);
      chk(req, oe_p, v[1]);
      chk(req, oe_n, v[0]);
    end
    ch_en_p = 0; ch_en_n = 0; pwm_p = 0; pwm_n = 0; dt_idle_ok = 0;

    // R2 active-high break clears moe immediately and it stays cleared
    brk_in = '0;
    cfg(2'b01, 2'b01, 2'b00, 0, 0, 0);
    @(negedge clk);
    pulse_set();
    chk("R3 set", moe, 1);
    brk_in[0] = 1;
    #1;
    chk("R2 immediate", moe, 0);
    chk("R2 oe off", oe_p, 0);
    @(negedge clk);
    chk("R12 flag set", brk_flag, 1);
    brk_in[0] = 0;
    @(negedge clk);
    chk("R2 latched", moe, 0);
    pulse_clr_flag();
    chk("R12 flag clear", brk_flag, 0);

    // R2 active-low
    brk_in[0] = 1;
    cfg(2'b01, 2'b00, 2'b00, 0, 0, 0);
    @(negedge clk);
    pulse_clr_flag();
    pulse_set();
    chk("R2 low pol idle", moe, 1);
    brk_in[0] = 0;
    #1;
    chk("R2 low pol active", moe, 0);

    // R3 break beats set; clear works
    @(negedge clk);
    pulse_set();
    chk("R3 set blocked", moe, 0);
    brk_in[0] = 1;
    pulse_set();
    chk("R3 set", moe, 1);
    moe_clr = 1; @(negedge clk); moe_clr = 0;
    chk("R3 clear", moe, 0);

    // R5 polarity lags one edge
    pulse_set();
    cfg(2'b01, 2'b01, 2'b00, 0, 0, 0);
    chk("R5 not yet live", moe, 1);
    @(negedge clk);
    chk("R5 live", moe, 0);

    // R4 automatic enable
    brk_in[0] = 0;
    cfg(2'b01, 2'b01, 2'b00, 1, 0, 0);
    @(negedge clk);
    upd_evt = 1; @(negedge clk); upd_evt = 0;
    chk("R4 auto set", moe, 1);
    moe_clr = 1; @(negedge clk); moe_clr = 0;
    cfg(2'b01, 2'b01, 2'b00, 0, 0, 0);
    upd_evt = 1; @(negedge clk); upd_evt = 0;
    chk("R4 aoe off", moe, 0);
    cfg(2'b01, 2'b01, 2'b00, 1, 0, 0);
    brk_in[0] = 1;
    upd_evt = 1; @(negedge clk); upd_evt = 0;
    chk("R4 break blocks", moe, 0);
    brk_in[0] = 0;
    cfg(2'b00, 2'b00, 2'b00, 0, 0, 0);
    @(negedge clk);

    // R9 upper break gated by off-state bits
    brk_in[1] = 1;
    cfg(2'b10, 2'b10, 2'b00, 0, 0, 0);
    @(negedge clk);
    pulse_set();
    chk("R9 ignored", moe, 1);
    cfg(2'b10, 2'b10, 2'b00, 0, 1, 1);
    #1;
    chk("R9 acts", moe, 0);
    chk("R8 forced", oe_p, 1);
    chk("R8 inactive", out_p, 0);
    brk_in[1] = 0;
    cfg(2'b00, 2'b00, 2'b00, 0, 0, 0);
    @(negedge clk);
    pulse_clr_flag();

    // R10 bidirectional pin ignored when mode off
    brk_in[0] = 1;
    cfg(2'b01, 2'b01, 2'b00, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    chk("R10 no bid", brk_pin_low[0], 0);
    brk_in[0] = 0;

    // R10 / R11 fault gone before disarm
    cfg(2'b01, 2'b01, 2'b01, 0, 0, 0);
    @(negedge clk);
    brk_in[0] = 1;
    @(negedge clk);
    chk("R10 drive", brk_pin_low[0], 1);
    brk_in[0] = 0;
    @(negedge clk); @(negedge clk);
    chk("R10 held", brk_pin_low[0], 1);
    dsrm_wr[0] = 1; @(negedge clk); dsrm_wr[0] = 0;
    chk("R11 lag", dsrm[0], 0);
    @(negedge clk);
    chk("R11 set", dsrm[0], 1);
    chk("R11 pin still", brk_pin_low[0], 1);
    @(negedge clk);
    chk("R11 released", brk_pin_low[0], 0);
    chk("R11 hw clear", dsrm[0], 0);

    // R11 fault still present at disarm
    brk_in[0] = 1;
    @(negedge clk);
    chk("R10 drive again", brk_pin_low[0], 1);
    dsrm_wr[0] = 1; @(negedge clk); dsrm_wr[0] = 0;
    @(negedge clk);
    chk("R11 set", dsrm[0], 1);
    @(negedge clk);
    chk("R11 released", brk_pin_low[0], 0);
    chk("R11 held active", dsrm[0], 1);
    brk_in[0] = 0;
    @(negedge clk);
    chk("R11 hw clear", dsrm[0], 0);
    @(negedge clk);
    chk("R11 stays released", brk_pin_low[0], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule